// File: doc/BRIEF.md
# Indirect Transmit Pointer Table

This block holds one 10-bit transmit starting-block pointer for each of 256 channels. The host reaches the table only through two 16-bit registers. It first loads a block number into the pointer register. It then writes the select register with a channel index and a command bit. That write opens an access, and a busy flag stays raised until the access is complete. A write command copies the pointer register into the channel's entry. A read command fetches the entry back into the pointer register.

A serializer engine shares the table through a separate update port. Each time the engine moves a channel on to its next block, it overwrites that channel's entry. A host read therefore returns the block the engine is currently using, which may differ from the value the host last wrote. The host may write any block number as a starting point. When the engine and a host access want the table in the same cycle, the engine goes first and the host access waits one cycle.

The control state machine has three states. `ST_IDLE` moves to `ST_ACCESS` when a select write is accepted. `ST_ACCESS` stays where it is when the engine holds the table in that cycle. Otherwise a write command returns it to `ST_IDLE`, and a read command moves it to `ST_FETCH`. `ST_FETCH` loads the fetched entry into the pointer register and returns to `ST_IDLE`. Busy is 1 in every state other than `ST_IDLE`.

Top module: `txptr_indirect`

## Requirements
- R1: After reset, both register read ports are 0 and busy is 0.
- R2: When idle, a write to the pointer register (reg_addr=0) stores reg_wdata[9:0]. Bits 15:10 of ptr_rdata always read 0.
- R3: A select write (reg_addr=1) with bit 14 = 1, accepted while idle, raises busy (sel_rdata bit 15) from the next cycle. With no engine update in the way, busy falls one cycle later and the entry holds the pointer register value.
- R4: A select write with bit 14 = 0 starts a read. Busy stays 1 for two cycles. When busy falls, ptr_rdata holds the addressed entry.
- R5: Select bits 7:0 index the entry. Index 00h is the first channel and FFh is the last, and each index addresses its own entry.
- R6: While busy is 1, writes to either register are ignored. The channel, the command and the pointer register keep their values.
- R7: An engine update (eng_upd=1) writes eng_ptr into entry eng_chan at the next clock edge. A later host read returns that value.
- R8: When an engine update falls on the cycle in which a host access would use the table, the engine update takes effect. The host access runs one cycle later, so busy lasts one cycle longer.
- R9: sel_rdata shows busy in bit 15, the last accepted command in bit 14, 0 in bits 13:8 and the last accepted channel in bits 7:0.
- R10: All 10 pointer bits are kept. Values 000h, 1FFh and 3FFh are returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 1 | Register select: 0 = pointer register, 1 = select register |
| reg_wdata | input | 16 | Host write data |
| ptr_rdata | output | 16 | Pointer register read value |
| sel_rdata | output | 16 | Select register read value, including busy |
| eng_upd | input | 1 | Engine pointer update strobe |
| eng_chan | input | 8 | Channel the engine updates |
| eng_ptr | input | 10 | New current block for that channel |

## Verification
An engine update and a host access can both reach the table in the same cycle. The bench sets this up by raising eng_upd in the exact cycle that follows an accepted select write, which is the cycle the state machine spends in `ST_ACCESS`. For a read aimed at the same channel, the bench expects busy to last three cycles instead of two, and expects the read to return the engine's value. For a write aimed at a different channel, it expects busy to last two cycles, and expects both entries to read back with their own values afterwards.

// File: rtl/txp_pkg.sv
package txp_pkg;
    localparam int SEL_BUSY_BIT = 15;
    localparam int SEL_CMD_BIT  = 14;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FETCH  = 2'd2
    } acc_state_t;
endpackage

// File: rtl/txp_ram.sv
module txp_ram #(
    parameter int AW = 8,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

    // R8: the arbiter never lets a host read share a cycle with any write
    p_port_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/txp_arb.sv
module txp_arb #(
    parameter int AW = 8,
    parameter int DW = 10
) (
    input  logic          eng_upd,
    input  logic [AW-1:0] eng_chan,
    input  logic [DW-1:0] eng_ptr,
    input  logic          host_req,
    input  logic          host_is_wr,
    input  logic [AW-1:0] host_chan,
    input  logic [DW-1:0] host_ptr,
    output logic          host_grant,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr
);
    always_comb begin
        host_grant = host_req && !eng_upd;
        ram_re     = host_grant && !host_is_wr;
        ram_raddr  = host_chan;
        if (eng_upd) begin
            ram_we    = 1'b1;
            ram_waddr = eng_chan;
            ram_wdata = eng_ptr;
        end else begin
            ram_we    = host_grant && host_is_wr;
            ram_waddr = host_chan;
            ram_wdata = host_ptr;
        end
    end
endmodule

// File: rtl/txp_fsm.sv
module txp_fsm
    import txp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic       cmd_is_rd,
    input  logic       grant,
    output acc_state_t state,
    output logic       busy,
    output logic       host_req,
    output logic       load_ptr
);
    acc_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd_go) state_nx = ST_ACCESS;
            ST_ACCESS: if (grant)  state_nx = cmd_is_rd ? ST_FETCH : ST_IDLE;
            ST_FETCH:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        host_req = (state == ST_ACCESS);
        load_ptr = (state == ST_FETCH);
    end

    // R8: a stalled host access waits in ST_ACCESS for the next cycle
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && !grant) |=> (state == ST_ACCESS));
    // R3: an accepted command always enters ST_ACCESS
    p_go_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> (state == ST_ACCESS));
endmodule

// File: rtl/txptr_indirect.sv
module txptr_indirect
    import txp_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int PTR_W  = 10,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  ptr_rdata,
    output logic [REG_W-1:0]  sel_rdata,
    input  logic              eng_upd,
    input  logic [CHAN_W-1:0] eng_chan,
    input  logic [PTR_W-1:0]  eng_ptr
);
    localparam logic ADDR_PTR = 1'b0;
    localparam logic ADDR_SEL = 1'b1;

    acc_state_t        state;
    logic              busy, host_req, load_ptr, grant, cmd_go;
    logic [PTR_W-1:0]  ptr_q;
    logic [CHAN_W-1:0] chan_q;
    logic              cmd_wr_q;
    logic              ram_we, ram_re;
    logic [CHAN_W-1:0] ram_waddr, ram_raddr;
    logic [PTR_W-1:0]  ram_wdata, ram_rdata;
    logic              unused_wdata_par;

    assign unused_wdata_par = ^reg_wdata;
    assign cmd_go = reg_we && (reg_addr == ADDR_SEL) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            chan_q   <= '0;
            cmd_wr_q <= 1'b0;
        end else begin
            if (load_ptr) begin
                ptr_q <= ram_rdata;
            end else if (reg_we && reg_addr == ADDR_PTR && !busy) begin
                ptr_q <= reg_wdata[PTR_W-1:0];
            end
            if (cmd_go) begin
                chan_q   <= reg_wdata[CHAN_W-1:0];
                cmd_wr_q <= reg_wdata[SEL_CMD_BIT];
            end
        end
    end

    always_comb begin
        ptr_rdata = '0;
        ptr_rdata[PTR_W-1:0] = ptr_q;
        sel_rdata = '0;
        sel_rdata[CHAN_W-1:0]   = chan_q;
        sel_rdata[SEL_CMD_BIT]  = cmd_wr_q;
        sel_rdata[SEL_BUSY_BIT] = busy;
    end

    txp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_is_rd (!cmd_wr_q),
        .grant     (grant),
        .state     (state),
        .busy      (busy),
        .host_req  (host_req),
        .load_ptr  (load_ptr)
    );

    txp_arb #(.AW(CHAN_W), .DW(PTR_W)) u_arb (
        .eng_upd    (eng_upd),
        .eng_chan   (eng_chan),
        .eng_ptr    (eng_ptr),
        .host_req   (host_req),
        .host_is_wr (cmd_wr_q),
        .host_chan  (chan_q),
        .host_ptr   (ptr_q),
        .host_grant (grant),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .ram_re     (ram_re),
        .ram_raddr  (ram_raddr)
    );

    txp_ram #(.AW(CHAN_W), .DW(PTR_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // R6: a select write during busy leaves the channel and the command alone
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == ADDR_SEL) |=> ($stable(chan_q) && $stable(cmd_wr_q)));
    // R6: a pointer write during busy, outside the fetch cycle, is dropped
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_ptr && reg_we && reg_addr == ADDR_PTR) |=> $stable(ptr_q));
    // R4: the fetch cycle moves the table output into the pointer register
    p_fetch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_ptr |=> (ptr_q == $past(ram_rdata)));
    // R3: a write command with no engine contention finishes in one cycle
    p_wr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && cmd_wr_q && !eng_upd) |=> !busy);
    // R8: the engine's write reaches the table whatever the host is doing
    p_eng_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_upd |-> (ram_we && ram_waddr == eng_chan && ram_wdata == eng_ptr));
endmodule

// File: tb/test_txptr_indirect.sv
`timescale 1ns/1ps
module test_txptr_indirect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ptr_rdata, sel_rdata;
    logic        eng_upd = 1'b0;
    logic [7:0]  eng_chan = '0;
    logic [9:0]  eng_ptr = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txptr_indirect i_txptr_indirect (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ptr_rdata(ptr_rdata), .sel_rdata(sel_rdata),
        .eng_upd(eng_upd), .eng_chan(eng_chan), .eng_ptr(eng_ptr)
    );

    // each entry: {channel[7:0], pointer[9:0]}
    localparam logic [17:0] VEC [6] = '{
        {8'h00, 10'h000}, {8'hFF, 10'h3FF}, {8'h01, 10'h1FF},
        {8'h80, 10'h2AA}, {8'h7F, 10'h155}, {8'h10, 10'h001}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic host_cmd(input logic [7:0] ch, input logic wr);
        reg_write(1'b1, {1'b0, wr, 6'b0, ch});
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (sel_rdata[15] && n < 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_check(input string req, input logic [7:0] ch, input logic [9:0] exp);
        int n;
        host_cmd(ch, 1'b0);
        chk({req, " R4 busy raised"}, 16'(sel_rdata[15]), 16'd1);
        wait_idle(n);
        chk({req, " R4 read busy cycles"}, 16'(n), 16'd2);
        chk({req, " R4 read value"}, ptr_rdata, {6'b0, exp});
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ptr after reset", ptr_rdata, 16'h0000);
        chk("R1 sel after reset", sel_rdata, 16'h0000);

        foreach (VEC[i]) begin
            reg_write(1'b0, {6'b0, VEC[i][9:0]});
            chk("R2 pointer register", ptr_rdata, {6'b0, VEC[i][9:0]});
            host_cmd(VEC[i][17:10], 1'b1);
            chk("R3 R9 sel during write", sel_rdata, {8'hC0, VEC[i][17:10]});
            wait_idle(n);
            chk("R3 write busy cycles", 16'(n), 16'd1);
        end

        reg_write(1'b0, 16'hFFFF);
        chk("R2 R10 upper bits dropped", ptr_rdata, 16'h03FF);

        foreach (VEC[i]) begin
            read_check("R5 R10", VEC[i][17:10], VEC[i][9:0]);
            chk("R9 sel after read", sel_rdata, {8'h00, VEC[i][17:10]});
        end

        // R7: engine update alone
        @(negedge clk);
        eng_upd = 1'b1; eng_chan = 8'h10; eng_ptr = 10'h2F0;
        @(negedge clk);
        eng_upd = 1'b0;
        read_check("R7 engine value", 8'h10, 10'h2F0);

        // R8: engine update to the same channel as a host read
        host_cmd(8'h05, 1'b0);
        eng_upd = 1'b1; eng_chan = 8'h05; eng_ptr = 10'h2AA;
        @(negedge clk);
        eng_upd = 1'b0;
        chk("R8 read stalled busy", 16'(sel_rdata[15]), 16'd1);
        @(negedge clk);
        chk("R8 read fetch busy", 16'(sel_rdata[15]), 16'd1);
        @(negedge clk);
        chk("R8 read done", 16'(sel_rdata[15]), 16'd0);
        chk("R8 read sees engine value", ptr_rdata, 16'h02AA);

        // R8: engine update to another channel during a host write
        reg_write(1'b0, 16'h0100);
        host_cmd(8'h07, 1'b1);
        eng_upd = 1'b1; eng_chan = 8'h09; eng_ptr = 10'h0CC;
        @(negedge clk);
        eng_upd = 1'b0;
        chk("R8 write stalled busy", 16'(sel_rdata[15]), 16'd1);
        @(negedge clk);
        chk("R8 write done", 16'(sel_rdata[15]), 16'd0);
        read_check("R8 host entry", 8'h07, 10'h100);
        read_check("R8 engine entry", 8'h09, 10'h0CC);

        // R6: select write while a read is busy
        host_cmd(8'hFF, 1'b0);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h4001;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R6 busy during ignored sel", 16'(sel_rdata[15]), 16'd1);
        @(negedge clk);
        chk("R6 read completes", sel_rdata, 16'h00FF);
        chk("R6 read value kept", ptr_rdata, 16'h03FF);
        read_check("R6 entry untouched", 8'h01, 10'h1FF);

        // R6: pointer write while a host write is busy
        reg_write(1'b0, 16'h00AB);
        host_cmd(8'h40, 1'b1);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h03CC;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R6 write done", 16'(sel_rdata[15]), 16'd0);
        chk("R6 pointer register kept", ptr_rdata, 16'h00AB);
        read_check("R6 written entry", 8'h40, 10'h0AB);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule